// File: doc/BRIEF.md
# Background Debug Data Register

This block is the data register that a JTAG test access port selects when its debug instruction is loaded. It lets a host trade command and data bytes with on-chip debug logic over ordinary DR-scans while the processor keeps running. Each scan moves ten bits. The host's command or data byte occupies the top eight bits and the low two bits are ignored. On the way out, the same top eight bits carry a byte from an 8-bit holding buffer and the low two bits carry a status code. In background operation the status code is always 00.

The TAP controller itself lives outside this block. It supplies the capture, shift and update strobes, the 3-bit instruction and the test clock. Capture and shift act on the rising edge of the test clock. Update acts on the falling edge: the shifted-in byte is taken into the holding buffer and is also presented on `host_byte`.

Two opcodes request a read, one for a control byte and one for a flag byte. After such an opcode is taken in, the selected value is parked in the holding buffer and comes out on the following scan. The byte the host shifts in during that follow-on scan is discarded.

The JTAG clock cannot be stalled, so the host-byte output is a plain level. It carries no valid/ready handshake and offers no back-pressure. A downstream consumer must take the byte within one scan.

When in-system programming claims the shift path, this block stands aside completely.

Top module: `bgdbg_dr`

## Requirements
- R1: With any instruction other than 3'b010, no strobe changes the shift register, the holding buffer or `host_byte`, and `tdo` is 0.
- R2: On a Capture-DR cycle while selected, bits 9..2 of the shift register take the holding buffer.
- R3: On a Shift-DR cycle while selected, the shift register moves one place toward bit 0 on the rising clock edge, with `tdi` entering bit 9. `tdo` shows bit 0, so the ten output bits leave in order 0 to 9.
- R4: The status bits 1..0 captured for output are always 00.
- R5: On the falling clock edge of an Update-DR cycle (outside a follow-on scan), `host_byte` takes shift-register bits 9..2. Outside Update-DR, neither `host_byte` nor the holding buffer changes.
- R6: Opcode 0x01 taken at update loads `ctrl_reg` into the holding buffer, so the next scan returns it in bits 9..2.
- R7: Opcode 0x02 taken at update loads `flag_reg` into the holding buffer, so the next scan returns it in bits 9..2.
- R8: The update that ends the follow-on scan after a read ignores the incoming byte: `host_byte` holds, no new read starts, and the holding buffer clears to 0x00.
- R9: Any opcode other than 0x01 or 0x02 (0x00 included) starts no read. The holding buffer takes the byte itself, and the next scan returns it.
- R10: While `isp_en` is high, the block ignores all strobes and drives `tdo` to 0, even with instruction 3'b010.
- R11: While `trst_n` is low, the shift register, the holding buffer, `host_byte` and the pending-read state are all 0, and `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| ir | input | 3 | Current instruction; 3'b010 selects this register |
| isp_en | input | 1 | In-system programming owns the shift path |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial data from the host |
| ctrl_reg | input | 8 | Control byte offered for read |
| flag_reg | input | 8 | Flag byte offered for read |
| tdo | output | 1 | Serial data to the host |
| host_byte | output | 8 | Last byte taken in from the host |

## Verification
Two functions can fall on the same falling edge: the update that retires a pending read and the decode of a fresh opcode. This happens when the follow-on scan itself carries a read opcode. The bench provokes it by shifting 0x02 as the follow-on byte after a 0x01 read. It then expects the control byte out, `host_byte` unchanged, and 0x00 rather than the flag byte on the scan after. A second overlap arises when programming priority and a selected debug instruction are present together. Here the bench expects silence on `tdo` and an untouched holding buffer, as seen on the next ordinary scan.

// File: rtl/bgdbg_pkg.sv
package bgdbg_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned STAT_W = 2;
  localparam int unsigned IR_W   = 3;
  localparam int unsigned NUM_RD = 2;

  localparam logic [IR_W-1:0]   IR_DEBUG      = 3'b010;
  localparam logic [STAT_W-1:0] ST_BACKGROUND = 2'b00;

  // read opcodes are 1..NUM_RD; source i answers opcode i+1
  localparam logic [DATA_W-1:0] OP_NOP     = 8'h00;
  localparam logic [DATA_W-1:0] OP_RD_CTRL = 8'h01;
  localparam logic [DATA_W-1:0] OP_RD_FLAG = 8'h02;
endpackage

// File: rtl/bgdbg_shift.sv
module bgdbg_shift #(
  parameter int unsigned DATA_W = bgdbg_pkg::DATA_W,
  parameter int unsigned STAT_W = bgdbg_pkg::STAT_W,
  parameter logic [STAT_W-1:0] STATUS = bgdbg_pkg::ST_BACKGROUND,
  localparam int unsigned SR_W = DATA_W + STAT_W
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              cap_en,
  input  logic              sh_en,
  input  logic              tdi,
  input  logic [DATA_W-1:0] hold,
  output logic [SR_W-1:0]   sr_q
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (cap_en) begin
      sr_q <= {hold, STATUS};
    end else if (sh_en) begin
      sr_q <= {tdi, sr_q[SR_W-1:1]};
    end
  end
endmodule

// File: rtl/bgdbg_decoder.sv
module bgdbg_decoder #(
  parameter int unsigned DATA_W = bgdbg_pkg::DATA_W,
  parameter int unsigned NUM_RD = bgdbg_pkg::NUM_RD
) (
  input  logic [DATA_W-1:0]        opcode,
  input  logic [NUM_RD*DATA_W-1:0] rd_src,
  output logic                     rd_hit,
  output logic [DATA_W-1:0]        rd_val
);
  logic [NUM_RD-1:0] match;

  for (genvar i = 0; i < NUM_RD; i++) begin : g_match
    assign match[i] = (opcode == DATA_W'(i + 1));
  end

  always_comb begin
    rd_hit = |match;
    rd_val = '0;
    for (int i = 0; i < NUM_RD; i++) begin
      if (match[i]) rd_val = rd_src[i*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/bgdbg_hold.sv
module bgdbg_hold #(
  parameter int unsigned DATA_W = bgdbg_pkg::DATA_W
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] rd_val,
  output logic [DATA_W-1:0] hold_q,
  output logic [DATA_W-1:0] host_q,
  output logic              pend_q
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      hold_q <= '0;
      host_q <= '0;
      pend_q <= 1'b0;
    end else if (upd_en) begin
      if (pend_q) begin
        hold_q <= '0;
        pend_q <= 1'b0;
      end else begin
        host_q <= in_byte;
        pend_q <= rd_hit;
        hold_q <= rd_hit ? rd_val : in_byte;
      end
    end
  end
endmodule

// File: rtl/bgdbg_dr.sv
module bgdbg_dr #(
  parameter int unsigned DATA_W = bgdbg_pkg::DATA_W,
  parameter int unsigned STAT_W = bgdbg_pkg::STAT_W,
  parameter int unsigned IR_W   = bgdbg_pkg::IR_W,
  parameter logic [IR_W-1:0] IR_SEL = bgdbg_pkg::IR_DEBUG,
  localparam int unsigned SR_W  = DATA_W + STAT_W
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [IR_W-1:0]   ir,
  input  logic              isp_en,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  input  logic [DATA_W-1:0] ctrl_reg,
  input  logic [DATA_W-1:0] flag_reg,
  output logic              tdo,
  output logic [DATA_W-1:0] host_byte
);
  logic              sel;
  logic [SR_W-1:0]   sr_q;
  logic [DATA_W-1:0] hold_q;
  logic              pend_q;
  logic              rd_hit;
  logic [DATA_W-1:0] rd_val;

  assign sel = (ir == IR_SEL) && !isp_en;
  assign tdo = sel & sr_q[0];

  bgdbg_shift #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_shift (
    .tck(tck), .trst_n(trst_n),
    .cap_en(sel & capture_dr), .sh_en(sel & shift_dr),
    .tdi(tdi), .hold(hold_q), .sr_q(sr_q)
  );

  bgdbg_decoder #(.DATA_W(DATA_W), .NUM_RD(2)) u_dec (
    .opcode(sr_q[SR_W-1:STAT_W]),
    .rd_src({flag_reg, ctrl_reg}),
    .rd_hit(rd_hit), .rd_val(rd_val)
  );

  bgdbg_hold #(.DATA_W(DATA_W)) u_hold (
    .tck(tck), .trst_n(trst_n), .upd_en(sel & update_dr),
    .in_byte(sr_q[SR_W-1:STAT_W]), .rd_hit(rd_hit), .rd_val(rd_val),
    .hold_q(hold_q), .host_q(host_byte), .pend_q(pend_q)
  );
endmodule

// File: rtl/bgdbg_dr_chk.sv
module bgdbg_dr_chk #(
  parameter int unsigned DATA_W = bgdbg_pkg::DATA_W,
  parameter int unsigned STAT_W = bgdbg_pkg::STAT_W,
  localparam int unsigned SR_W  = DATA_W + STAT_W
) (
  input logic              tck,
  input logic              trst_n,
  input logic              sel,
  input logic              isp_en,
  input logic              capture_dr,
  input logic              shift_dr,
  input logic              update_dr,
  input logic              tdi,
  input logic              tdo,
  input logic [DATA_W-1:0] ctrl_reg,
  input logic [DATA_W-1:0] flag_reg,
  input logic [SR_W-1:0]   sr_q,
  input logic [DATA_W-1:0] hold_q,
  input logic [DATA_W-1:0] host_byte,
  input logic              pend_q
);
  p_quiet_r1: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |=> $stable(sr_q));

  p_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
    sel && capture_dr |=> sr_q[SR_W-1:STAT_W] == $past(hold_q));

  p_shift_r3: assert property (@(posedge tck) disable iff (!trst_n)
    sel && shift_dr && !capture_dr |=> sr_q == {$past(tdi), $past(sr_q[SR_W-1:1])});

  p_status_zero_r4: assert property (@(posedge tck) disable iff (!trst_n)
    sel && capture_dr |=> sr_q[STAT_W-1:0] == '0);

  p_hold_stable_r5: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel && update_dr) |-> $stable(hold_q) && $stable(host_byte));

  p_read_ctrl_r6: assert property (@(posedge tck) disable iff (!trst_n)
    sel && update_dr && !$past(pend_q) && sr_q[SR_W-1:STAT_W] == 8'h01
      |-> hold_q == ctrl_reg && pend_q);

  p_read_flag_r7: assert property (@(posedge tck) disable iff (!trst_n)
    sel && update_dr && !$past(pend_q) && sr_q[SR_W-1:STAT_W] == 8'h02
      |-> hold_q == flag_reg && pend_q);

  p_followon_r8: assert property (@(posedge tck) disable iff (!trst_n)
    sel && update_dr && $past(pend_q) |-> hold_q == '0 && !pend_q && $stable(host_byte));

  p_isp_silent_r10: assert property (@(posedge tck) disable iff (!trst_n)
    isp_en |-> !tdo);
endmodule

bind bgdbg_dr bgdbg_dr_chk u_chk (
  .tck(tck), .trst_n(trst_n), .sel(sel), .isp_en(isp_en),
  .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
  .tdi(tdi), .tdo(tdo), .ctrl_reg(ctrl_reg), .flag_reg(flag_reg),
  .sr_q(sr_q), .hold_q(hold_q), .host_byte(host_byte), .pend_q(pend_q)
);

// File: tb/bgdbg_dr_test.sv
module bgdbg_dr_test;
  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic [2:0] ir = 3'b010;
  logic       isp_en = 1'b0;
  logic       capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
  logic [7:0] ctrl_reg = 8'h00, flag_reg = 8'h00;
  logic       tdo;
  logic [7:0] host_byte;

  always #2 tck = ~tck;  // 250 MHz

  bgdbg_dr uut (
    .tck(tck), .trst_n(trst_n), .ir(ir), .isp_en(isp_en),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .ctrl_reg(ctrl_reg), .flag_reg(flag_reg),
    .tdo(tdo), .host_byte(host_byte)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // behavioural reference
  bit [9:0] m_sr = '0;
  bit [7:0] m_hold = '0, m_host = '0;
  bit       m_pend = 1'b0;

  function automatic bit m_sel();
    return (ir == 3'b010) && !isp_en;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_rise();
    if (!trst_n) begin
      m_sr = '0;
    end else if (m_sel()) begin
      if (capture_dr) m_sr = {m_hold, 2'b00};
      else if (shift_dr) m_sr = {tdi, m_sr[9:1]};
    end
  endtask

  task automatic model_fall();
    if (!trst_n) begin
      m_hold = '0; m_host = '0; m_pend = 1'b0;
    end else if (m_sel() && update_dr) begin
      if (m_pend) begin
        m_hold = '0; m_pend = 1'b0;
      end else begin
        m_host = m_sr[9:2];
        if (m_sr[9:2] == 8'h01) begin m_hold = ctrl_reg; m_pend = 1'b1; end
        else if (m_sr[9:2] == 8'h02) begin m_hold = flag_reg; m_pend = 1'b1; end
        else m_hold = m_sr[9:2];
      end
    end
  endtask

  // one clock: model the rising edge, drive, model the falling edge, compare
  task automatic tick(input bit cap, input bit sh, input bit upd, input bit din);
    @(posedge tck);
    model_rise();
    #1;
    capture_dr = cap; shift_dr = sh; update_dr = upd; tdi = din;
    model_fall();
    #2;
    check("R3 tdo", int'(tdo), int'(m_sel() ? m_sr[0] : 1'b0));
    check("R5 host_byte", int'(host_byte), int'(m_host));
  endtask

  task automatic dr_scan(input bit [7:0] b, output bit [9:0] got);
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < 10; j++) begin
      tick(1'b0, 1'b1, 1'b0, (j < 2) ? 1'b0 : b[j-2]);
      got[j] = tdo;
    end
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit [9:0] g;
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 reset tdo", int'(tdo), 0);
    check("R11 reset host_byte", int'(host_byte), 0);
    #1 trst_n = 1'b1;
    tick(1'b0, 1'b0, 1'b0, 1'b0);

    dr_scan(8'h5A, g);
    check("R4 status bits", int'(g[1:0]), 0);
    check("R2 first out", int'(g[9:2]), 8'h00);
    check("R5 host latched", int'(host_byte), 8'h5A);
    dr_scan(8'h00, g);
    check("R2 echo out", int'(g[9:2]), 8'h5A);
    check("R4 status bits", int'(g[1:0]), 0);

    ctrl_reg = 8'hC3; flag_reg = 8'h3C;
    dr_scan(8'h01, g);
    check("R5 host opcode", int'(host_byte), 8'h01);
    dr_scan(8'h02, g);   // follow-on carries a read opcode
    check("R6 ctrl read", int'(g[9:2]), 8'hC3);
    check("R8 host held", int'(host_byte), 8'h01);
    dr_scan(8'h00, g);
    check("R8 follow-on no read", int'(g[9:2]), 8'h00);

    dr_scan(8'h02, g);
    dr_scan(8'h00, g);
    check("R7 flag read", int'(g[9:2]), 8'h3C);
    check("R8 host held", int'(host_byte), 8'h02);

    dr_scan(8'h9F, g);
    check("R9 after clear", int'(g[9:2]), 8'h00);
    dr_scan(8'h00, g);
    check("R9 unsupported echo", int'(g[9:2]), 8'h9F);

    dr_scan(8'h66, g);
    ir = 3'b011;
    dr_scan(8'hAA, g);
    check("R1 tdo silent", int'(g), 0);
    check("R1 host held", int'(host_byte), 8'h66);
    ir = 3'b010;
    dr_scan(8'h00, g);
    check("R1 hold kept", int'(g[9:2]), 8'h66);

    dr_scan(8'h55, g);
    isp_en = 1'b1;
    dr_scan(8'h01, g);
    check("R10 tdo silent", int'(g), 0);
    check("R10 host held", int'(host_byte), 8'h55);
    isp_en = 1'b0;
    dr_scan(8'h00, g);
    check("R10 no read started", int'(g[9:2]), 8'h55);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule